// File: doc/BRIEF.md
# MIDI Serial Byte Receiver

This block turns the asynchronous MIDI serial line into parallel bytes. The line is first retimed into the system clock domain. A controller then waits for a genuine high-to-low transition, times the middle of every bit period from that edge, and shifts the data bits into a working register, least significant bit first. At the middle of the stop bit it decides whether the frame was good. A good byte is copied into a separate holding register that drives the output, together with a strobe lasting a single clock cycle. A bad byte is dropped.

Because the output byte sits in its own register, the working register can accept the next frame while a downstream reader still has the previous byte. The bit period is a parameter. The default of 384 suits a 12 MHz clock at 31.25 kbit/s. A frame is one low start bit, eight data bits and one high stop bit.

The controller has five named states:
- `ST_WAIT_HIGH` is entered from reset and after every stop bit. It moves to `ST_ARMED` once the retimed line is high.
- `ST_ARMED` moves to `ST_START_MID` when the line goes low.
- `ST_START_MID` counts half a bit period. The level of the start bit is not checked. It then moves to `ST_DATA`.
- `ST_DATA` samples one data bit at the end of each full bit period. After the last data bit it moves to `ST_STOP`.
- `ST_STOP` samples the stop bit one bit period later and returns to `ST_WAIT_HIGH`.

Top module: `midi_byte_rx`

## Requirements
- R1: While reset (synchronous, active high) is asserted, and in the first cycle after it, `byte_valid` is 0 and `byte_out` is all zeros; the controller starts in the state that waits for a high line.
- R2: The serial input passes through a two-flop synchronizer that is reset low, so a line held low from reset onward never starts a frame.
- R3: A frame starts only on a high-to-low transition of the retimed line seen after the line was high.
- R4: Counting rising clock edges after the serial input falls for the start bit, `byte_valid` for a good frame is registered high on edge number HALF + (DATA_BITS+1)*BIT_CYCLES + 3, where HALF = BIT_CYCLES/2.
- R5: Data bits are taken least significant first. Bit i of `byte_out` is the line value sampled HALF + (i+1)*BIT_CYCLES cycles after the start of the frame.
- R6: If the sampled stop bit is high, `byte_out` takes the received byte, without start or stop bits, and `byte_valid` pulses.
- R7: If the sampled stop bit is low, the frame is discarded: `byte_out` keeps its previous value and no pulse is produced.
- R8: After a low stop bit, a line that stays low starts no new frame; a later high-then-low sequence starts a frame normally.
- R9: Frames sent back to back with no idle time are all received, and `byte_out` holds each byte until the next good frame ends.
- R10: `byte_valid` is never high for two consecutive cycles.
- R11: The start-bit level is not rechecked: a low pulse of only a few cycles followed by a high line is received as byte 0xFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| midi_in | input | 1 | Asynchronous serial MIDI line, idle high |
| byte_out | output | DATA_BITS | Last byte received with a good stop bit |
| byte_valid | output | 1 | One-cycle strobe when `byte_out` is updated |

## Verification
The bench builds the receiver with BIT_CYCLES = 16 and DATA_BITS = 8. With these values a frame takes 160 cycles instead of 3840, so many frames fit in a short run, and the exact strobe latency of 155 cycles can be checked against the formula. A half period of 8 cycles still leaves several cycles of margin around the synchronizer delay, which keeps the centre sampling meaningful. The same counter and comparison paths run at the default 384.

// File: rtl/midi_rx_pkg.sv
package midi_rx_pkg;

    // Controller states for the serial byte receiver
    typedef enum logic [2:0] {
        ST_WAIT_HIGH = 3'd0,
        ST_ARMED     = 3'd1,
        ST_START_MID = 3'd2,
        ST_DATA      = 3'd3,
        ST_STOP      = 3'd4
    } rx_state_t;

endpackage

// File: rtl/midi_rx_sync.sv
module midi_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_q;

    // Reset low so a line held low out of reset never looks like a high
    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], din};
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/midi_rx_bit_timer.sv
module midi_rx_bit_timer #(
    parameter int BIT_CYCLES = 384
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output logic half_done,
    output logic bit_done
);

    localparam int HALF = BIT_CYCLES / 2;
    localparam int CW   = $clog2(BIT_CYCLES);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr)                         cnt_q <= '0;
        else if (cnt_q == CW'(BIT_CYCLES - 1))  cnt_q <= '0;
        else                                    cnt_q <= cnt_q + 1'b1;
    end

    assign half_done = (cnt_q == CW'(HALF - 1));
    assign bit_done  = (cnt_q == CW'(BIT_CYCLES - 1));

endmodule

// File: rtl/midi_rx_ctrl.sv
module midi_rx_ctrl
    import midi_rx_pkg::*;
#(
    parameter int DATA_BITS = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic line,
    input  logic half_done,
    input  logic bit_done,
    output logic timer_clr,
    output logic shift_en,
    output logic stop_en
);

    localparam int IW = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;

    rx_state_t     state_q, state_d;
    logic [IW-1:0] bit_idx_q;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT_HIGH;
        else     state_q <= state_d;
    end

    // Data bit position within the frame
    always_ff @(posedge clk) begin
        if (rst)                        bit_idx_q <= '0;
        else if (state_q == ST_START_MID) bit_idx_q <= '0;
        else if (shift_en)              bit_idx_q <= bit_idx_q + 1'b1;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_HIGH: if (line)      state_d = ST_ARMED;
            ST_ARMED:     if (!line)     state_d = ST_START_MID;
            ST_START_MID: if (half_done) state_d = ST_DATA;
            ST_DATA:      if (bit_done && bit_idx_q == IW'(DATA_BITS - 1))
                                         state_d = ST_STOP;
            ST_STOP:      if (bit_done)  state_d = ST_WAIT_HIGH;
            default:                     state_d = ST_WAIT_HIGH;
        endcase
    end

    // Outputs
    always_comb begin
        timer_clr = (state_q != state_d);
        shift_en  = (state_q == ST_DATA) && bit_done;
        stop_en   = (state_q == ST_STOP) && bit_done;
    end

    // R3: the half-bit count is entered only from the armed state
    assert_start_from_armed_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(state_q == ST_START_MID) |-> $past(state_q) == ST_ARMED);

    // R8: after the stop sample the detector must wait for a high line again
    assert_rearm_after_stop_R8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_STOP && bit_done) |=> state_q == ST_WAIT_HIGH);

    // R5: data position stays inside the byte while sampling
    assert_bit_index_range_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_DATA) |-> (int'(bit_idx_q) < DATA_BITS));

endmodule

// File: rtl/midi_byte_rx.sv
module midi_byte_rx #(
    parameter int BIT_CYCLES = 384,
    parameter int DATA_BITS  = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 midi_in,
    output logic [DATA_BITS-1:0] byte_out,
    output logic                 byte_valid
);

    logic line_s;
    logic half_done, bit_done;
    logic timer_clr, shift_en, stop_en;
    logic [DATA_BITS-1:0] shift_q;

    midi_rx_sync #(.STAGES(2)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (midi_in),
        .dout (line_s)
    );

    midi_rx_bit_timer #(.BIT_CYCLES(BIT_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .clr       (timer_clr),
        .half_done (half_done),
        .bit_done  (bit_done)
    );

    midi_rx_ctrl #(.DATA_BITS(DATA_BITS)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .line      (line_s),
        .half_done (half_done),
        .bit_done  (bit_done),
        .timer_clr (timer_clr),
        .shift_en  (shift_en),
        .stop_en   (stop_en)
    );

    // Working register: newest bit enters at the top, so the first bit lands in bit 0
    always_ff @(posedge clk) begin
        if (rst)           shift_q <= '0;
        else if (shift_en) shift_q <= {line_s, shift_q[DATA_BITS-1:1]};
    end

    // Output holding register and strobe
    always_ff @(posedge clk) begin
        if (rst) begin
            byte_out   <= '0;
            byte_valid <= 1'b0;
        end else begin
            byte_valid <= stop_en && line_s;
            if (stop_en && line_s) byte_out <= shift_q;
        end
    end

    // R10: strobe lasts one cycle
    assert_valid_single_R10: assert property (@(posedge clk) disable iff (rst)
        byte_valid |=> !byte_valid);

    // R6: a strobe follows only a stop sample that was high
    assert_valid_needs_stop_R6: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> ($past(stop_en) && $past(line_s)));

    // R7: the held byte changes only at a stop sample
    assert_hold_output_R7: assert property (@(posedge clk) disable iff (rst)
        !stop_en |=> $stable(byte_out));

endmodule

// File: tb/test_midi_byte_rx.sv
`timescale 1ns/1ps
module test_midi_byte_rx;

    localparam int BIT  = 16;
    localparam int NB   = 8;
    localparam int HALF = BIT / 2;
    localparam int LAT  = HALF + (NB + 1) * BIT + 3;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          midi_in = 1'b0;
    logic [NB-1:0] byte_out;
    logic          byte_valid;

    int total = 0, bad = 0;
    int cyc = 0, vcount = 0, last_vcyc = 0, width_err = 0;
    logic [NB-1:0] last_data = '0;
    logic prev_valid = 1'b0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    midi_byte_rx #(.BIT_CYCLES(BIT), .DATA_BITS(NB)) i_midi_byte_rx (
        .clk        (clk),
        .rst        (rst),
        .midi_in    (midi_in),
        .byte_out   (byte_out),
        .byte_valid (byte_valid)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (byte_valid) begin
            vcount    <= vcount + 1;
            last_data <= byte_out;
            last_vcyc <= cyc;
            if (prev_valid) width_err <= width_err + 1;
        end
        prev_valid <= byte_valid;
    end

    task automatic check(string req, int act, int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic hold(logic v, int n);
        midi_in = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_frame(logic [NB-1:0] b, logic stop);
        hold(1'b0, BIT);
        for (int i = 0; i < NB; i++) hold(b[i], BIT);
        hold(stop, BIT);
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 valid in reset", int'(byte_valid), 0);
        check("R1 data in reset", int'(byte_out), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 valid after reset", int'(byte_valid), 0);
    endtask

    task automatic t_low_from_reset;
        hold(1'b0, 4 * BIT);
        check("R2 no frame on held low", vcount, 0);
        check("R2 data unchanged", int'(byte_out), 0);
    endtask

    task automatic t_latency_lsb;
        int c0, n0;
        hold(1'b1, 2 * BIT);
        n0 = vcount;
        c0 = cyc;
        send_frame(8'h2C, 1'b1);
        check("R6 one strobe", vcount - n0, 1);
        check("R5 lsb first 0x2C", int'(last_data), 'h2C);
        check("R4 strobe latency", last_vcyc - c0, LAT);
        check("R6 data on port", int'(byte_out), 'h2C);
    endtask

    task automatic t_bad_stop;
        int n0;
        n0 = vcount;
        hold(1'b1, 2 * BIT);
        send_frame(8'h77, 1'b0);
        hold(1'b0, 3 * BIT);
        check("R7 no strobe on low stop", vcount - n0, 0);
        check("R7 data kept", int'(byte_out), 'h2C);
        check("R8 held low starts nothing", vcount - n0, 0);
        hold(1'b1, 2 * BIT);
        send_frame(8'h81, 1'b1);
        check("R8 rearm after high", vcount - n0, 1);
        check("R8 data 0x81", int'(byte_out), 'h81);
    endtask

    task automatic t_back_to_back;
        int n0;
        hold(1'b1, BIT);
        n0 = vcount;
        send_frame(8'h5A, 1'b1);
        check("R9 first byte", int'(byte_out), 'h5A);
        send_frame(8'hC3, 1'b1);
        check("R9 second byte", int'(byte_out), 'hC3);
        check("R9 two strobes", vcount - n0, 2);
        hold(1'b1, 3 * BIT);
        check("R9 byte held", int'(byte_out), 'hC3);
    endtask

    task automatic t_glitch_start;
        int n0;
        n0 = vcount;
        hold(1'b0, 3);
        hold(1'b1, 10 * BIT);
        check("R11 short start accepted", vcount - n0, 1);
        check("R11 data 0xFF", int'(byte_out), 'hFF);
    endtask

    task automatic t_zero_byte;
        send_frame(8'h00, 1'b1);
        hold(1'b1, BIT);
        check("R5 byte 0x00", int'(byte_out), 'h00);
        check("R10 strobe width", width_err, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset();
        t_low_from_reset();
        t_latency_lsb();
        t_bad_stop();
        t_back_to_back();
        t_glitch_start();
        t_zero_byte();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule